// File: doc/BRIEF.md
# Serial Command Frame Encoder

This block sits on the host side of a serial register and bulk-transfer link. It accepts one transaction request at a time and turns it into the byte sequence of a command frame. A request carries an opcode, a 24-bit address, 32-bit write data, a transfer length and two flags: one marks a low-power register access and one enables the check byte. Each opcode has its own frame layout and length. The bytes leave one per cycle on a valid/ready stream, and a separate shifter turns them into pin activity.

When the check byte is enabled, a 7-bit CRC is accumulated bit-serially as the bytes are handed over. It is sent as a final byte, shifted left so that its lowest bit is zero. An opcode the block does not know is refused with a single-cycle error pulse, and no byte is sent for it.

Top module: `cmd_frame_encoder`

## Requirements
- R1: After a synchronous active-low reset the encoder is idle: `req_ready`=1, `busy`=0, `out_valid`=0, `err`=0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `busy` is 1 and `req_ready` is 0 from the cycle after acceptance until the cycle after the last byte is taken. After that the encoder is idle again.
- R3: Byte 0 of every frame is the opcode. Frame lengths with the check byte: 0xCA, 0xC4, 0xC5, 0xC6 and 0xCF give 5; 0xC1 and 0xC2 give 7; 0xC7, 0xC8 and 0xC3 give 8; 0xC9 gives 9.
- R4: Opcodes 0xC1, 0xC2, 0xC7, 0xC8, 0xC9 and 0xCA send address bits 23:16, 15:8 and 7:0 in that order in bytes 1 to 3. Opcodes 0xC3 and 0xC4 send address bits 15:8 in byte 1 and bits 7:0 in byte 2. Bit 7 of byte 1 is forced to 1 when `req_lowpwr` is set.
- R5: 0xC1 and 0xC2 send length bits 15:8 then 7:0 in bytes 4 and 5. 0xC7 and 0xC8 send length bits 23:16, 15:8 and 7:0 in bytes 4 to 6.
- R6: Write data goes out most-significant byte first. For 0xC3 it occupies bytes 3 to 6; for 0xC9 it occupies bytes 4 to 7.
- R7: 0xC5 and 0xC6 fill bytes 1 to 3 with 0x00. 0xCF fills them with 0xFF. 0xC4 sends 0x00 in byte 3.
- R8: With `req_crc_en`=1 the final byte is {crc[6:0],1'b0}. Here crc is the CRC7 with polynomial x^7+x^3+1 (0x09), seeded with 0x7F and fed MSB first over every earlier byte of the frame.
- R9: With `req_crc_en`=0 the check byte is omitted and the frame is one byte shorter.
- R10: `out_last` is 1 exactly while the final byte of the frame is offered.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R12: An opcode outside the list in R3 raises `err` for exactly one cycle, the cycle after the request. No byte is sent for it and the encoder stays idle.
- R13: Requests presented while `busy`=1 are ignored. They change neither the frame in progress nor what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder idle, can take a request |
| req_cmd | input | 8 | Opcode |
| req_addr | input | 24 | Target address |
| req_wdata | input | 32 | Write data for register writes |
| req_len | input | 24 | Transfer length for bulk commands |
| req_lowpwr | input | 1 | Sets bit 7 of the first address byte of 0xC3/0xC4 |
| req_crc_en | input | 1 | Append the CRC7 check byte |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| busy | output | 1 | Frame in progress |
| err | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
Each of the eleven opcodes is sent with the check byte on. Several are repeated with it off, so the layouts and the dropped byte are told apart. The low-power flag is driven both ways, with address values whose bit 15 is clear and set, which separates forcing bit 7 from copying it. The consumer is driven with three patterns: always ready, alternate cycles, and pseudo-random stalls. These catch a byte index or CRC that advances without a handshake. Requests injected mid-frame and unknown opcodes (0x00, 0xC0, 0xCB, 0xFF) check that the frame is not disturbed and that refusal sends nothing.

// File: rtl/cfe_pkg.sv
// Package: opcodes, request record and frame-size constants shared by the
// frame encoder and its checker. Assumes byte-wide output.
package cfe_pkg;

    typedef enum logic [7:0] {
        OP_BULK_WR   = 8'hC1,
        OP_BULK_RD   = 8'hC2,
        OP_LOCAL_WR  = 8'hC3,
        OP_LOCAL_RD  = 8'hC4,
        OP_STOP      = 8'hC5,
        OP_AGAIN     = 8'hC6,
        OP_XBULK_WR  = 8'hC7,
        OP_XBULK_RD  = 8'hC8,
        OP_WORD_WR   = 8'hC9,
        OP_WORD_RD   = 8'hCA,
        OP_RESET     = 8'hCF
    } opcode_e;

    localparam int BODY_MAX = 8;                       // longest frame without check byte
    localparam int IDX_W    = $clog2(BODY_MAX + 1);    // index covers the check byte too
    localparam int SEL_W    = $clog2(BODY_MAX);

    typedef struct packed {
        logic [7:0]  cmd;
        logic [23:0] addr;
        logic [31:0] wdata;
        logic [23:0] len;
        logic        lowpwr;
    } frame_req_t;

endpackage

// File: rtl/cfe_layout.sv
// Layout decoder: from a request, builds the frame body (every byte except
// the check byte) and its byte count, and flags whether the opcode is known.
// Purely combinational; assumes the request is stable while it is sampled.
module cfe_layout
    import cfe_pkg::*;
(
    input  frame_req_t              req,
    output logic                    known,
    output logic [IDX_W-1:0]        body_len,
    output logic [BODY_MAX*8-1:0]   body
);

    logic [7:0] local_hi;

    // First address byte of local-register commands, with the low-power mark.
    always_comb local_hi = {req.addr[15] | req.lowpwr, req.addr[14:8]};

    // Per-opcode byte placement; byte k lives at body[8k +: 8].
    always_comb begin
        body        = '0;
        body[7:0]   = req.cmd;
        known       = 1'b1;
        body_len    = IDX_W'(4);
        case (req.cmd)
            OP_WORD_RD: begin
                body[31:8] = {req.addr[7:0], req.addr[15:8], req.addr[23:16]};
            end
            OP_LOCAL_RD: begin
                body[15:8]  = local_hi;
                body[23:16] = req.addr[7:0];
                body[31:24] = 8'h00;
            end
            OP_STOP, OP_AGAIN: begin
                body[31:8] = 24'h000000;
            end
            OP_RESET: begin
                body[31:8] = 24'hFFFFFF;
            end
            OP_BULK_WR, OP_BULK_RD: begin
                body[31:8]  = {req.addr[7:0], req.addr[15:8], req.addr[23:16]};
                body[47:32] = {req.len[7:0], req.len[15:8]};
                body_len    = IDX_W'(6);
            end
            OP_XBULK_WR, OP_XBULK_RD: begin
                body[31:8]  = {req.addr[7:0], req.addr[15:8], req.addr[23:16]};
                body[55:32] = {req.len[7:0], req.len[15:8], req.len[23:16]};
                body_len    = IDX_W'(7);
            end
            OP_LOCAL_WR: begin
                body[15:8]  = local_hi;
                body[23:16] = req.addr[7:0];
                body[55:24] = {req.wdata[7:0], req.wdata[15:8],
                               req.wdata[23:16], req.wdata[31:24]};
                body_len    = IDX_W'(7);
            end
            OP_WORD_WR: begin
                body[31:8]  = {req.addr[7:0], req.addr[15:8], req.addr[23:16]};
                body[63:32] = {req.wdata[7:0], req.wdata[15:8],
                               req.wdata[23:16], req.wdata[31:24]};
                body_len    = IDX_W'(8);
            end
            default: begin
                known    = 1'b0;
                body_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/cfe_crc7.sv
// Serial CRC7 accumulator: folds one byte per step, MSB first, with no table.
// Assumes init and step are never both high in the same cycle.
module cfe_crc7 #(
    parameter logic [6:0] SEED = 7'h7F,
    parameter logic [6:0] POLY = 7'h09
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       step,
    input  logic [7:0] din,
    output logic [6:0] crc
);

    logic [6:0] crc_q;
    logic [6:0] crc_nx;

    // Eight unrolled shift/xor stages over the incoming byte.
    always_comb begin
        crc_nx = crc_q;
        for (int b = 7; b >= 0; b--) begin
            if (crc_nx[6] ^ din[b]) crc_nx = {crc_nx[5:0], 1'b0} ^ POLY;
            else                    crc_nx = {crc_nx[5:0], 1'b0};
        end
    end

    // Remainder register: seeded at frame start, advanced per handed-over byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= SEED;
        else if (init)   crc_q <= SEED;
        else if (step)   crc_q <= crc_nx;
    end

    assign crc = crc_q;

endmodule

// File: rtl/cfe_byte_sel.sv
// Output byte selector: picks the body byte at the current index, or the
// left-justified check byte when the index points past the body.
module cfe_byte_sel
    import cfe_pkg::*;
#(
    parameter int N = BODY_MAX
) (
    input  logic [N*8-1:0]          body,
    input  logic [$clog2(N)-1:0]    sel,
    input  logic                    pick_crc,
    input  logic [6:0]              crc,
    output logic [7:0]              dout
);

    logic [7:0] lane [N];

    // Slice the flat body into byte lanes.
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lane[g] = body[g*8 +: 8];
    end

    // Final multiplexer.
    always_comb dout = pick_crc ? {crc, 1'b0} : lane[sel];

endmodule

// File: rtl/cmd_frame_encoder.sv
// Command frame encoder top: accepts one request when idle, latches its
// layout, then streams the frame bytes over valid/ready, appending a CRC7
// byte when enabled. Unknown opcodes give a one-cycle error and no bytes.
// Assumes the consumer obeys valid/ready; requests while busy are dropped.
module cmd_frame_encoder
    import cfe_pkg::*;
#(
    parameter logic [6:0] CRC_SEED = 7'h7F,
    parameter logic [6:0] CRC_POLY = 7'h09
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_cmd,
    input  logic [23:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [23:0] req_len,
    input  logic        req_lowpwr,
    input  logic        req_crc_en,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        busy,
    output logic        err
);

    typedef enum logic {ST_IDLE, ST_SEND} state_e;

    state_e                 state_q;
    logic [BODY_MAX*8-1:0]  body_q;
    logic [IDX_W-1:0]       blen_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   crc_on_q;
    logic                   err_q;

    frame_req_t             req_in;
    logic                   known;
    logic [IDX_W-1:0]       body_len;
    logic [BODY_MAX*8-1:0]  body;
    logic                   accept;
    logic                   fire;
    logic                   at_crc;
    logic [IDX_W-1:0]       last_idx;
    logic [6:0]             crc;

    // Pack the request ports into one record.
    always_comb req_in = '{cmd: req_cmd, addr: req_addr, wdata: req_wdata,
                           len: req_len, lowpwr: req_lowpwr};

    cfe_layout u_layout (
        .req      (req_in),
        .known    (known),
        .body_len (body_len),
        .body     (body)
    );

    // Handshake and position decode.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        fire     = (state_q == ST_SEND) && out_ready;
        at_crc   = crc_on_q && (idx_q == blen_q);
        last_idx = crc_on_q ? blen_q : IDX_W'(blen_q - IDX_W'(1));
    end

    // Sequencer: idle/send state, latched layout, byte index and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            body_q   <= '0;
            blen_q   <= '0;
            idx_q    <= '0;
            crc_on_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (accept) begin
                if (known) begin
                    state_q  <= ST_SEND;
                    body_q   <= body;
                    blen_q   <= body_len;
                    crc_on_q <= req_crc_en;
                    idx_q    <= '0;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (fire) begin
                if (idx_q == last_idx) state_q <= ST_IDLE;
                idx_q <= IDX_W'(idx_q + IDX_W'(1));
            end
        end
    end

    cfe_crc7 #(
        .SEED (CRC_SEED),
        .POLY (CRC_POLY)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (accept),
        .step  (fire && !at_crc),
        .din   (out_data),
        .crc   (crc)
    );

    cfe_byte_sel #(
        .N (BODY_MAX)
    ) u_sel (
        .body     (body_q),
        .sel      (idx_q[SEL_W-1:0]),
        .pick_crc (at_crc),
        .crc      (crc),
        .dout     (out_data)
    );

    // Port drives.
    always_comb begin
        busy      = (state_q == ST_SEND);
        req_ready = (state_q == ST_IDLE);
        out_valid = (state_q == ST_SEND);
        out_last  = (state_q == ST_SEND) && (idx_q == last_idx);
        err       = err_q;
    end

endmodule

// File: rtl/cfe_checks.sv
// Checker for the frame encoder: protocol and timing properties over its
// ports and the latched check-byte enable. Attached by bind below.
module cfe_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       busy,
    input logic       err,
    input logic       crc_on
);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R12
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R12
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid && req_ready);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> req_ready && !busy && !out_valid);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy || err);

    // R8
    crc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && crc_on |-> !out_data[0]);

endmodule

bind cmd_frame_encoder cfe_checks u_cfe_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .busy      (busy),
    .err       (err),
    .crc_on    (crc_on_q)
);

// File: tb/cmd_frame_encoder_bench.sv
module cmd_frame_encoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [23:0] req_len = '0;
    logic        req_lowpwr = 1'b0;
    logic        req_crc_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic        busy;
    logic        err;

    int n_vec  = 0;
    int n_miss = 0;
    int cycles = 0;
    int lfsr   = 32'h1D2C3B4A;

    always #5 clk = ~clk;

    cmd_frame_encoder u_cmd_frame_encoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_len(req_len), .req_lowpwr(req_lowpwr), .req_crc_en(req_crc_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .busy(busy), .err(err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_miss++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    // Reference CRC7 by long division over the message bits.
    function automatic int ref_crc(input byte unsigned m[$]);
        int r = 'h7F;
        foreach (m[i]) begin
            for (int b = 7; b >= 0; b--) begin
                int top = ((r >> 6) & 1) ^ ((m[i] >> b) & 1);
                r = (r << 1) & 'h7F;
                if (top != 0) r = r ^ 'h09;
            end
        end
        return r;
    endfunction

    // Expected frame and the requirement each byte belongs to.
    task automatic build(input int cmd, input int a, input int d, input int s,
                         input bit lp, input bit ce,
                         output byte unsigned q[$], output string t[$]);
        int hi;
        q = {}; t = {};
        q.push_back(8'(cmd)); t.push_back("R3");
        hi = ((a >> 8) & 'hFF) | (lp ? 'h80 : 0);
        case (cmd)
            'hCA, 'hC1, 'hC2, 'hC7, 'hC8, 'hC9: begin
                for (int k = 2; k >= 0; k--) begin q.push_back(8'(a >> (8*k))); t.push_back("R4"); end
            end
            'hC3, 'hC4: begin
                q.push_back(8'(hi)); t.push_back("R4");
                q.push_back(8'(a));  t.push_back("R4");
            end
            default: ;
        endcase
        case (cmd)
            'hC4: begin q.push_back(8'h00); t.push_back("R7"); end
            'hC5, 'hC6: repeat (3) begin q.push_back(8'h00); t.push_back("R7"); end
            'hCF: repeat (3) begin q.push_back(8'hFF); t.push_back("R7"); end
            'hC1, 'hC2: for (int k = 1; k >= 0; k--) begin q.push_back(8'(s >> (8*k))); t.push_back("R5"); end
            'hC7, 'hC8: for (int k = 2; k >= 0; k--) begin q.push_back(8'(s >> (8*k))); t.push_back("R5"); end
            'hC3, 'hC9: for (int k = 3; k >= 0; k--) begin q.push_back(8'(d >> (8*k))); t.push_back("R6"); end
            default: ;
        endcase
        if (ce) begin
            q.push_back(8'(ref_crc(q) << 1)); t.push_back("R8");
        end
    endtask

    function automatic bit ready_of(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        if (mode == 1) return cyc[0];
        lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
        return lfsr[3] | lfsr[7];
    endfunction

    task automatic frame(input int cmd, input int a, input int d, input int s,
                         input bit lp, input bit ce, input int mode, input bit poke,
                         input int exp_len);
        byte unsigned q[$];
        string t[$];
        int i = 0;
        int cyc = 0;
        build(cmd, a, d, s, lp, ce, q, t);
        check(q.size() == exp_len, ce ? "R3" : "R9", q.size(), exp_len);
        @(negedge clk);
        req_cmd = 8'(cmd); req_addr = 24'(a); req_wdata = 32'(d); req_len = 24'(s);
        req_lowpwr = lp; req_crc_en = ce; req_valid = 1'b1;
        #1 check(req_ready == 1'b1, "R2", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (i < q.size() && cyc < 200) begin
            out_ready = ready_of(mode, cyc);
            if (poke && cyc == 1) begin
                // R13: a request while busy must be dropped.
                req_valid = 1'b1; req_cmd = 8'hCF; req_crc_en = ~ce; req_addr = 24'h5A5A5A;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            check(out_valid == 1'b1 && busy == 1'b1 && req_ready == 1'b0, poke ? "R13" : "R2",
                  {out_valid, busy, req_ready}, 3'b110);
            if (out_ready) begin
                check(out_data == q[i], t[i], out_data, q[i]);
                check(out_last == (i == q.size() - 1), "R10", out_last, (i == q.size() - 1));
                i++;
            end else begin
                check(out_last == (i == q.size() - 1), "R11", out_last, (i == q.size() - 1));
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0; out_ready = 1'b0;
        #1 check(!out_valid && !busy && req_ready, poke ? "R13" : "R2",
                 {out_valid, busy, req_ready}, 3'b001);
        @(negedge clk);
        #1 check(!out_valid && !err, ce ? "R3" : "R9", {out_valid, err}, 0);
    endtask

    task automatic bad_op(input int cmd);
        @(negedge clk);
        req_cmd = 8'(cmd); req_valid = 1'b1; req_crc_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; out_ready = 1'b1;
        #1 check(err && !out_valid && req_ready, "R12", {err, out_valid, req_ready}, 3'b101);
        @(negedge clk);
        #1 check(!err && !out_valid && !busy, "R12", {err, out_valid, busy}, 0);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check(req_ready && !busy && !out_valid && !err, "R1",
                 {req_ready, busy, out_valid, err}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(req_ready && !out_valid, "R1", {req_ready, out_valid}, 2'b10);

        frame('hCA, 'h123456, 0, 0, 0, 1, 0, 0, 5);
        frame('hC4, 'h00AB30, 0, 0, 1, 1, 0, 0, 5);
        frame('hC4, 'h00D530, 0, 0, 0, 1, 1, 0, 5);
        frame('hC5, 'hFFFFFF, 'hFFFFFFFF, 'hFFFFFF, 0, 1, 0, 0, 5);
        frame('hC6, 'h111111, 0, 0, 1, 1, 2, 0, 5);
        frame('hCF, 0, 0, 0, 0, 1, 0, 0, 5);
        frame('hC1, 'hA1B2C3, 0, 'h001234, 0, 1, 1, 0, 7);
        frame('hC2, 'h00E824, 0, 'h00FFEE, 0, 1, 2, 1, 7);
        frame('hC7, 'h3C3C3C, 0, 'h0ABCDE, 0, 1, 0, 0, 8);
        frame('hC8, 'h010203, 0, 'hFEDCBA, 0, 1, 2, 0, 8);
        frame('hC3, 'h000024, 'hDEADBEEF, 0, 1, 1, 0, 0, 8);
        frame('hC3, 'h00FF00, 'h01020304, 0, 0, 1, 2, 0, 8);
        frame('hC9, 'h001000, 'hCAFEF00D, 0, 0, 1, 1, 1, 9);
        frame('hC9, 'h7F8081, 'h89ABCDEF, 0, 0, 0, 0, 0, 8);
        frame('hCA, 'h000001, 0, 0, 0, 0, 2, 0, 4);
        frame('hC7, 'h123456, 0, 'h000001, 0, 0, 1, 1, 7);
        frame('hC4, 'h0000FF, 0, 0, 1, 0, 0, 0, 4);
        frame('hCF, 0, 0, 0, 0, 0, 2, 0, 4);

        bad_op('h00);
        bad_op('hC0);
        bad_op('hCB);
        bad_op('hFF);

        frame('hC1, 'h000000, 0, 'h000000, 0, 1, 0, 0, 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule